// File: doc/BRIEF.md
# Serial Exchange Sorter over a Four-Entry Register File

This block sorts four unsigned values into ascending order using one comparator and a handful of registers instead of a sorting network. While the sorter is idle, software-side logic loads the four entries one at a time through an addressed write port. A start request then launches a nested-loop exchange sort. An outer index `i` walks entries 0 to 2, and an inner index `j` walks the entries above `i`.

Two working registers hold the current minimum candidate (`A`, read from entry `i`) and the challenger (`B`, read from entry `j`). When the challenger is strictly smaller, the two entries trade places over two write cycles. First `A` is written into entry `j`, then `B` is written into entry `i`.

A single address multiplexer picks `i` or `j` for both the entry read and the write decoder. A small controller with one idle state and nine sort states runs the sequence:

| State | Action |
|---|---|
| `ST_IDLE` | Accepts loads and reads |
| `ST_CLR_I` | Clears `i` |
| `ST_LOAD_A` | Loads `A` from entry `i`, copies `i` into `j` |
| `ST_INC_J` | Increments `j` |
| `ST_LOAD_B` | Loads `B` from entry `j` |
| `ST_COMPARE` | Branches on the comparison |
| `ST_WR_J` | Writes `A` into entry `j` |
| `ST_WR_I` | Writes `B` into entry `i` |
| `ST_RELOAD` | Reloads `A` from entry `i` and tests the loop flags |
| `ST_FINISH` | Raises done |

The transitions are:

- `ST_IDLE` to `ST_CLR_I` on start.
- `ST_CLR_I` to `ST_LOAD_A`.
- `ST_LOAD_A` to `ST_INC_J`.
- `ST_INC_J` to `ST_LOAD_B`.
- `ST_LOAD_B` to `ST_COMPARE`.
- `ST_COMPARE` to `ST_WR_J` when `B < A`, and to `ST_RELOAD` otherwise.
- `ST_WR_J` to `ST_WR_I`.
- `ST_WR_I` to `ST_RELOAD`.
- `ST_RELOAD` branches on the loop flags:
  - back to `ST_INC_J` while `j` is below 3;
  - to `ST_LOAD_A`, with `i` incremented, when `j` is 3 and `i` is below 2;
  - to `ST_FINISH` when `j` is 3 and `i` is 2.
- `ST_FINISH` stays while start is high, and returns to `ST_IDLE` when start is low.

Top module: `xsort_top`

## Requirements
- R1: After reset, busy and done are low and all four entries read back as zero.
- R2: In idle, a cycle with `load_en` high writes `load_data` into the entry selected by `load_addr` (2-bit, 0 to 3). The new value is visible on `rd_data` in the next cycle.
- R3: `load_en` is ignored in every state other than idle, including the finish state. No entry changes.
- R4: A start level sampled high in idle makes busy high from the next cycle.
- R5: When done rises, entries 0 to 3 hold the loaded values as unsigned numbers in non-decreasing order, as a permutation of the inputs.
- R6: The sort takes exactly 28 + 2*S busy cycles, where S is the number of strict exchanges (`B < A`) made by the nested loop. Equal values are never exchanged.
- R7: Done stays high while start remains high. Once start is low at a clock edge in the finish state, done falls and the block is idle.
- R8: While busy, `rd_data` is zero. Otherwise `rd_data` equals the entry at `rd_addr`, combinationally.
- R9: Start seen while busy has no effect on the sequence or its length.
- R10: Busy and done are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Entry write request, honoured only when idle |
| load_addr | input | 2 | Entry index for a load |
| load_data | input | DATA_W | Value to load |
| start | input | 1 | Start level; also holds done in the finish state |
| rd_addr | input | 2 | Entry index for readback |
| rd_data | output | DATA_W | Entry value, zero while busy |
| busy | output | 1 | Sort in progress |
| done | output | 1 | Sort finished, held while start stays high |

## Verification
The assertions assume that start is a level that the environment holds or drops between clock edges. They also assume that `load_addr` and `rd_addr` always carry a defined value. The bound on busy length assumes no reset pulse mid-sort.

The bench drives every input at the falling edge. It keeps start high through the finish state when it tests the hold, and it issues loads and stray start pulses mid-sort only to confirm that they are ignored.

// File: rtl/xsort_pkg.sv
package xsort_pkg;
    localparam int ENTRIES = 4;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int LAST_I  = ENTRIES - 2;
    localparam int LAST_J  = ENTRIES - 1;
    localparam int PAIRS   = ENTRIES * (ENTRIES - 1) / 2;
    // busy cycles with no exchange: clear + outer loads + four per pair
    localparam int BASE_CYCLES = 1 + (ENTRIES - 1) + 4 * PAIRS;
    localparam int MAX_CYCLES  = BASE_CYCLES + 2 * PAIRS;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLR_I,
        ST_LOAD_A,
        ST_INC_J,
        ST_LOAD_B,
        ST_COMPARE,
        ST_WR_J,
        ST_WR_I,
        ST_RELOAD,
        ST_FINISH
    } xsort_state_e;

    typedef struct packed {
        logic clr_i;
        logic inc_i;
        logic cpy_j;
        logic inc_j;
        logic ld_a;
        logic ld_b;
        logic sel_j;
        logic pick_b;
        logic sort_we;
        logic idle;
        logic busy;
        logic done;
    } xsort_ctl_t;
endpackage

// File: rtl/xsort_regfile.sv
module xsort_regfile
    import xsort_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  sort_raddr,
    output logic [DATA_W-1:0] sort_rdata,
    input  logic [IDX_W-1:0]  ext_raddr,
    output logic [DATA_W-1:0] ext_rdata
);
    logic [DATA_W-1:0] entry_q [ENTRIES];
    logic [ENTRIES-1:0] dec_en;

    // gated 2-to-4 decoder
    always_comb begin
        dec_en = '0;
        if (we) dec_en[waddr] = 1'b1;
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        entry_q[e] <= '0;
            else if (dec_en[e]) entry_q[e] <= wdata;
        end
    end

    assign sort_rdata = entry_q[sort_raddr];
    assign ext_rdata  = entry_q[ext_raddr];
endmodule

// File: rtl/xsort_index.sv
module xsort_index
    import xsort_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic             cpy_j,
    input  logic             inc_j,
    output logic [IDX_W-1:0] i_q,
    output logic [IDX_W-1:0] j_q,
    output logic             i_last,
    output logic             j_last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     i_q <= '0;
        else if (clr_i) i_q <= '0;
        else if (inc_i) i_q <= i_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     j_q <= '0;
        else if (cpy_j) j_q <= i_q;
        else if (inc_j) j_q <= j_q + 1'b1;
    end

    assign i_last = (i_q == IDX_W'(LAST_I));
    assign j_last = (j_q == IDX_W'(LAST_J));
endmodule

// File: rtl/xsort_ctrl.sv
module xsort_ctrl
    import xsort_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         b_lt_a,
    input  logic         i_last,
    input  logic         j_last,
    output xsort_state_e state_q,
    output xsort_ctl_t   ctl
);
    xsort_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_CLR_I;
            ST_CLR_I:   state_d = ST_LOAD_A;
            ST_LOAD_A:  state_d = ST_INC_J;
            ST_INC_J:   state_d = ST_LOAD_B;
            ST_LOAD_B:  state_d = ST_COMPARE;
            ST_COMPARE: state_d = b_lt_a ? ST_WR_J : ST_RELOAD;
            ST_WR_J:    state_d = ST_WR_I;
            ST_WR_I:    state_d = ST_RELOAD;
            ST_RELOAD: begin
                if (!j_last)     state_d = ST_INC_J;
                else if (!i_last) state_d = ST_LOAD_A;
                else             state_d = ST_FINISH;
            end
            ST_FINISH:  if (!start) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl = '0;
        unique case (state_q)
            ST_IDLE:    ctl.idle = 1'b1;
            ST_CLR_I: begin
                ctl.busy  = 1'b1;
                ctl.clr_i = 1'b1;
            end
            ST_LOAD_A: begin
                ctl.busy  = 1'b1;
                ctl.ld_a  = 1'b1;
                ctl.cpy_j = 1'b1;
            end
            ST_INC_J: begin
                ctl.busy  = 1'b1;
                ctl.inc_j = 1'b1;
            end
            ST_LOAD_B: begin
                ctl.busy  = 1'b1;
                ctl.sel_j = 1'b1;
                ctl.ld_b  = 1'b1;
            end
            ST_COMPARE: ctl.busy = 1'b1;
            ST_WR_J: begin
                ctl.busy    = 1'b1;
                ctl.sel_j   = 1'b1;
                ctl.sort_we = 1'b1;
            end
            ST_WR_I: begin
                ctl.busy    = 1'b1;
                ctl.pick_b  = 1'b1;
                ctl.sort_we = 1'b1;
            end
            ST_RELOAD: begin
                ctl.busy  = 1'b1;
                ctl.ld_a  = 1'b1;
                ctl.inc_i = j_last && !i_last;
            end
            ST_FINISH:  ctl.done = 1'b1;
            default:    ctl = '0;
        endcase
    end
endmodule

// File: rtl/xsort_top.sv
module xsort_top
    import xsort_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [1:0]        load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic              start,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done
);
    xsort_state_e      state_q;
    xsort_ctl_t        ctl;
    logic [IDX_W-1:0]  i_q, j_q, idx;
    logic              i_last, j_last, b_lt_a;
    logic [DATA_W-1:0] a_q, b_q, cell_q, ext_q;
    logic              rf_we;
    logic [IDX_W-1:0]  rf_waddr;
    logic [DATA_W-1:0] rf_wdata;

    xsort_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .b_lt_a(b_lt_a),
        .i_last(i_last), .j_last(j_last), .state_q(state_q), .ctl(ctl)
    );

    xsort_index u_index (
        .clk(clk), .rst_n(rst_n), .clr_i(ctl.clr_i), .inc_i(ctl.inc_i),
        .cpy_j(ctl.cpy_j), .inc_j(ctl.inc_j), .i_q(i_q), .j_q(j_q),
        .i_last(i_last), .j_last(j_last)
    );

    // index mux: one address for both sort read and write decode
    assign idx = ctl.sel_j ? j_q : i_q;

    // write path: external load only in idle, else A/B select
    assign rf_we    = (ctl.idle && load_en) || ctl.sort_we;
    assign rf_waddr = ctl.idle ? load_addr : idx;
    assign rf_wdata = ctl.idle ? load_data : (ctl.pick_b ? b_q : a_q);

    xsort_regfile #(.DATA_W(DATA_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr),
        .wdata(rf_wdata), .sort_raddr(idx), .sort_rdata(cell_q),
        .ext_raddr(rd_addr), .ext_rdata(ext_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        a_q <= '0;
        else if (ctl.ld_a) a_q <= cell_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        b_q <= '0;
        else if (ctl.ld_b) b_q <= cell_q;
    end

    assign b_lt_a  = (b_q < a_q);
    assign busy    = ctl.busy;
    assign done    = ctl.done;
    assign rd_data = ctl.busy ? '0 : ext_q;
endmodule

// File: rtl/xsort_checker.sv
module xsort_checker
    import xsort_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              load_en,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] a_q,
    input logic [DATA_W-1:0] b_q,
    input logic              rf_we,
    input xsort_state_e      state_q
);
    localparam int CNT_W = $clog2(MAX_CYCLES + 2);
    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R10
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> done); // R7
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (!done && !busy)); // R7
    AST_RD_ZERO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rd_data == '0)); // R8
    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && start) |=> busy); // R4
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < CNT_W'(MAX_CYCLES))); // R6
    AST_SWAP_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_J) |-> (b_q < a_q)); // R6
    AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && done) |-> !rf_we); // R3
endmodule

bind xsort_top xsort_checker #(.DATA_W(DATA_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .load_en(load_en),
    .busy(busy), .done(done), .rd_data(rd_data), .a_q(a_q), .b_q(b_q),
    .rf_we(rf_we), .state_q(state_q)
);

// File: tb/xsort_top_tb.sv
module xsort_top_tb;
    localparam int W = 8;
    // each vector: in0,in1,in2,in3, then expected sorted e0..e3
    localparam int NV = 6;
    localparam logic [63:0] VEC [NV] = '{
        {8'd4,   8'd3, 8'd2,   8'd1,  8'd1, 8'd2,   8'd3,   8'd4},
        {8'd1,   8'd2, 8'd3,   8'd4,  8'd1, 8'd2,   8'd3,   8'd4},
        {8'd5,   8'd5, 8'd5,   8'd5,  8'd5, 8'd5,   8'd5,   8'd5},
        {8'd255, 8'd0, 8'd128, 8'd7,  8'd0, 8'd7,   8'd128, 8'd255},
        {8'd9,   8'd9, 8'd1,   8'd1,  8'd1, 8'd1,   8'd9,   8'd9},
        {8'd3,   8'd1, 8'd3,   8'd2,  8'd1, 8'd2,   8'd3,   8'd3}
    };

    logic clk = 0, rst_n = 0, load_en = 0, start = 0;
    logic [1:0] load_addr = 0, rd_addr = 0;
    logic [W-1:0] load_data = 0;
    logic [W-1:0] rd_data;
    logic busy, done;
    int checks = 0, failures = 0;

    always #5 clk = ~clk;

    xsort_top #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .start(start), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .done(done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // exchange count of the nested-loop sort, from the requirement text
    function automatic int model_swaps(input logic [31:0] p);
        logic [7:0] r [4];
        logic [7:0] a, t;
        int s = 0;
        for (int k = 0; k < 4; k++) r[k] = p[31-8*k -: 8];
        for (int i = 0; i < 3; i++) begin
            a = r[i];
            for (int j = i + 1; j < 4; j++) begin
                if (r[j] < a) begin
                    t = r[i]; r[i] = r[j]; r[j] = t; s++;
                end
                a = r[i];
            end
        end
        return s;
    endfunction

    task automatic load(input logic [1:0] ad, input logic [W-1:0] d);
        @(negedge clk);
        load_en = 1; load_addr = ad; load_data = d;
        @(negedge clk);
        load_en = 0;
    endtask

    task automatic read_chk(input string req, input logic [1:0] ad, input logic [W-1:0] exp);
        rd_addr = ad;
        #1;
        check(req, rd_data, exp);
    endtask

    // run one sort; hold: keep start high through finish; poke: stray load and start mid-sort
    task automatic run_sort(input int exp_cycles, input bit hold, input bit poke);
        int n = 0;
        @(negedge clk);
        start = 1;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 1) begin
                check("R4 busy after start", busy, 1);
                if (!hold) start = 0;
            end
            if (poke) begin
                if (n == 5) begin load_en = 1; load_addr = 0; load_data = 8'hEE; end
                if (n == 6) load_en = 0;
                if (n == 8 && !hold) start = 1;
                if (n == 9 && !hold) start = 0;
                if (n == 10) read_chk("R8 zero while busy", 2'd0, 8'd0);
            end
            if (done || n > 200) break;
        end
        check(poke ? "R9 length with stray start" : "R6 sort length", n, exp_cycles + 1);
        check("R10 busy low at done", busy, 0);
        if (hold) begin
            for (int k = 0; k < 3; k++) begin
                load_en = 1; load_addr = 1; load_data = 8'hAB;
                @(negedge clk);
                check("R7 done held", done, 1);
            end
            load_en = 0;
            start = 0;
        end
        @(negedge clk);
        check("R7 done released", done, 0);
        check("R7 idle after release", busy, 0);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [W-1:0] in_v [4];
        logic [W-1:0] ex_v [4];
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        for (int k = 0; k < 4; k++) read_chk("R1 entry zero", 2'(k), 8'd0);
        rst_n = 1;

        // R2 load then readback
        load(2'd2, 8'h5A);
        read_chk("R2 load visible", 2'd2, 8'h5A);

        // table walk: R5, R6
        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < 4; k++) begin
                in_v[k] = VEC[v][63-8*k -: 8];
                ex_v[k] = VEC[v][31-8*k -: 8];
                load(2'(k), in_v[k]);
            end
            run_sort(28 + 2 * model_swaps(VEC[v][63:32]), 1'b0, 1'b0);
            for (int k = 0; k < 4; k++) read_chk("R5 sorted entry", 2'(k), ex_v[k]);
        end

        // R3 and R9: stray load (addr 0 = 0xEE) and start mid-sort
        load(0, 8'd40); load(1, 8'd30); load(2, 8'd20); load(3, 8'd10);
        run_sort(28 + 2 * 6, 1'b0, 1'b1);
        read_chk("R3 load ignored while busy", 2'd0, 8'd10);
        read_chk("R5 sorted entry", 2'd3, 8'd40);

        // R7 hold with start high; R3 loads in finish state ignored (addr 1 = 0xAB)
        load(0, 8'd7); load(1, 8'd7); load(2, 8'd6); load(3, 8'd8);
        run_sort(28 + 2 * model_swaps({8'd7, 8'd7, 8'd6, 8'd8}), 1'b1, 1'b0);
        read_chk("R3 load ignored in finish", 2'd1, 8'd7);
        read_chk("R5 sorted entry", 2'd0, 8'd6);
        read_chk("R8 readback idle", 2'd3, 8'd8);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule